// File: doc/BRIEF.md
# Dual-Channel Received Strength Peak Monitor

This block watches the quantised envelope level on two receive inputs of a contactless reader front end. For each channel it keeps the highest level seen while a receive window is open. The held pair stays readable after the packet ends. When the reader starts its next transmission, both held values return to zero, so the next reply starts from a clean floor. A routing control picks which physical input feeds the main channel and which feeds the auxiliary channel.

The same status byte also carries an oscillator-ready flag. A cycle timer raises the flag once the oscillator enable has been high for a set number of clocks, about 200 µs at 13.56 MHz. The byte is a plain parallel output and a register bus can sample it at any time.

Top module: `rssi_peak_status`

## Requirements
- R1: `statusByte` is formed as bit 7 = 0, bit 6 = oscillator ready, bits 5:3 = auxiliary held level, bits 2:0 = main held level. Each level is a 3-bit code: 0 means no signal and codes 1 to 7 rise in 4 dB steps.
- R2: On a clock edge where `rxActive` is 1 and `txStart` is 0, each held level becomes the larger of its current value and the input code routed to that channel.
- R3: On a clock edge where `rxActive` is 0 and `txStart` is 0, both held levels keep their value whatever the input codes are.
- R4: On a clock edge where `txStart` is 1, both held levels become 0. Any sample presented in the same cycle is discarded.
- R5: With `swapSel` = 0 the main channel samples `envA` and the auxiliary channel samples `envB`. With `swapSel` = 1 the main channel samples `envB` and the auxiliary channel samples `envA`.
- R6: Changing `swapSel` affects only later samples. Values already held are not exchanged between the channels.
- R7: The ready flag (bit 6) goes to 1 after `oscEn` has been 1 on OSC_WAIT consecutive clock edges, and not before. The default OSC_WAIT is 2712 cycles.
- R8: The ready flag is 0 in the same cycle that `oscEn` is 0, and the timer restarts from zero the next time `oscEn` rises.
- R9: Asserting `rstN` low clears both held levels, the timer and the ready flag at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| envA | input | 3 | Quantised level code from physical input A |
| envB | input | 3 | Quantised level code from physical input B |
| rxActive | input | 1 | Receive window open; enables peak capture |
| txStart | input | 1 | Transmit-start pulse; clears both held levels |
| swapSel | input | 1 | Input routing: 0 gives main = A, 1 gives main = B |
| oscEn | input | 1 | Oscillator enable; starts the ready timer |
| statusByte | output | 8 | Packed status: 0, ready, auxiliary, main |

## Verification
On every cycle the checker confirms four things. A transmit start leaves both levels at zero. Closed windows leave the levels untouched. Open windows never lower a level and leave each channel at or above the input routed to it. The ready flag stays low whenever the enable is low and never rises before the timer window has elapsed. The bench scenarios cover the rest: the exact cycle the flag rises, a clear and a sample landing in the same cycle, held values that stay in place when the routing flips, and an asynchronous reset taking effect between clock edges.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
  typedef struct packed {
    logic clearPeaks;
    logic loadPeaks;
    logic routeSwap;
  } peakCtrl_t;
endpackage

// File: rtl/rssi_ctrl.sv
module rssi_ctrl
  import rssi_pkg::*;
#(
  parameter int OSC_WAIT = 2712
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxActive,
  input  logic      txStart,
  input  logic      swapSel,
  input  logic      oscEn,
  output peakCtrl_t strobes,
  output logic      oscReady
);
  localparam int CNT_W = $clog2(OSC_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(OSC_WAIT);

  logic [CNT_W-1:0] waitCnt;
  logic             doneReg;

  // The transmit start has priority over a sample in the same cycle.
  always_comb begin
    strobes.clearPeaks = txStart;
    strobes.loadPeaks  = rxActive & ~txStart;
    strobes.routeSwap  = swapSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      doneReg <= 1'b0;
    end else if (!oscEn) begin
      waitCnt <= '0;
      doneReg <= 1'b0;
    end else if (waitCnt != CNT_DONE) begin
      waitCnt <= waitCnt + 1'b1;
      doneReg <= (waitCnt == CNT_DONE - 1'b1);
    end
  end

  // Gating with the enable drops the flag within the same cycle.
  assign oscReady = doneReg & oscEn;
endmodule

// File: rtl/rssi_datapath.sv
module rssi_datapath
  import rssi_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  peakCtrl_t         strobes,
  input  logic [CODE_W-1:0] envA,
  input  logic [CODE_W-1:0] envB,
  output logic [CODE_W-1:0] mainLevel,
  output logic [CODE_W-1:0] auxLevel
);
  localparam int NUM_CH = 2;

  logic [CODE_W-1:0] chIn   [NUM_CH];
  logic [CODE_W-1:0] chPeak [NUM_CH];

  // Channel 0 is main, channel 1 is auxiliary.
  assign chIn[0] = strobes.routeSwap ? envB : envA;
  assign chIn[1] = strobes.routeSwap ? envA : envB;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chPeak[ch] <= '0;
      end else if (strobes.clearPeaks) begin
        chPeak[ch] <= '0;
      end else if (strobes.loadPeaks && (chIn[ch] > chPeak[ch])) begin
        chPeak[ch] <= chIn[ch];
      end
    end
  end

  assign mainLevel = chPeak[0];
  assign auxLevel  = chPeak[1];
endmodule

// File: rtl/rssi_peak_status.sv
module rssi_peak_status
  import rssi_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int OSC_WAIT = 2712
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] envA,
  input  logic [CODE_W-1:0] envB,
  input  logic              rxActive,
  input  logic              txStart,
  input  logic              swapSel,
  input  logic              oscEn,
  output logic [7:0]        statusByte
);
  peakCtrl_t         strobes;
  logic              oscReady;
  logic [CODE_W-1:0] mainLevel;
  logic [CODE_W-1:0] auxLevel;

  rssi_ctrl #(.OSC_WAIT(OSC_WAIT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxActive (rxActive),
    .txStart  (txStart),
    .swapSel  (swapSel),
    .oscEn    (oscEn),
    .strobes  (strobes),
    .oscReady (oscReady)
  );

  rssi_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .envA      (envA),
    .envB      (envB),
    .mainLevel (mainLevel),
    .auxLevel  (auxLevel)
  );

  assign statusByte = {1'b0, oscReady, auxLevel, mainLevel};
endmodule

// File: rtl/rssi_peak_status_chk.sv
module rssi_peak_status_chk #(
  parameter int CODE_W   = 3,
  parameter int OSC_WAIT = 2712
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] envA,
  input logic [CODE_W-1:0] envB,
  input logic              rxActive,
  input logic              txStart,
  input logic              swapSel,
  input logic              oscEn,
  input logic [7:0]        statusByte
);
  localparam int CNT_W = $clog2(OSC_WAIT + 2);

  logic [CNT_W-1:0] enCycles;
  logic [2:0] mainV;
  logic [2:0] auxV;
  assign mainV = statusByte[2:0];
  assign auxV  = statusByte[5:3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        enCycles <= '0;
    else if (!oscEn)                  enCycles <= '0;
    else if (enCycles != CNT_W'(OSC_WAIT)) enCycles <= enCycles + 1'b1;
  end

  assert_tx_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> (statusByte[5:0] == 6'd0));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rxActive && !txStart) |=> $stable(statusByte[5:0]));

  assert_never_falls_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rxActive && !txStart) |=> (mainV >= $past(mainV)) && (auxV >= $past(auxV)));

  assert_route_direct_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxActive && !txStart && !swapSel) |=> (mainV >= $past(envA)) && (auxV >= $past(envB)));

  assert_route_swapped_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxActive && !txStart && swapSel) |=> (mainV >= $past(envB)) && (auxV >= $past(envA)));

  assert_flag_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> !statusByte[6]);

  assert_flag_not_early_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6] |-> (enCycles == CNT_W'(OSC_WAIT)));

  assert_top_bit_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[6]) |-> !statusByte[7]);
endmodule

bind rssi_peak_status rssi_peak_status_chk #(.CODE_W(CODE_W), .OSC_WAIT(OSC_WAIT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .envA       (envA),
  .envB       (envB),
  .rxActive   (rxActive),
  .txStart    (txStart),
  .swapSel    (swapSel),
  .oscEn      (oscEn),
  .statusByte (statusByte)
);

// File: tb/test_rssi_peak_status.sv
`timescale 1ns/1ps
module test_rssi_peak_status;
  localparam int WAIT = 40;
  localparam int NVEC = 10;
  // {txStart, rxActive, swapSel, envA[3], envB[3], expMain[3], expAux[3]}
  localparam logic [14:0] VECS [NVEC] = '{
    {3'b010, 3'd3, 3'd5, 3'd3, 3'd5},  // R2 first capture
    {3'b010, 3'd2, 3'd6, 3'd3, 3'd6},  // R2 max kept / raised
    {3'b000, 3'd7, 3'd7, 3'd3, 3'd6},  // R3 ignored when idle
    {3'b110, 3'd7, 3'd7, 3'd0, 3'd0},  // R4 clear wins over sample
    {3'b011, 3'd4, 3'd1, 3'd1, 3'd4},  // R5 swapped routing
    {3'b010, 3'd2, 3'd3, 3'd2, 3'd4},  // R6 no exchange on unswap
    {3'b010, 3'd7, 3'd0, 3'd7, 3'd4},  // R2 full scale
    {3'b011, 3'd5, 3'd6, 3'd7, 3'd5},  // R6 swap again, held stays
    {3'b100, 3'd0, 3'd0, 3'd0, 3'd0},  // R4 clear while idle
    {3'b011, 3'd0, 3'd7, 3'd7, 3'd0}   // R5 main from B
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] envA = '0, envB = '0;
  logic rxActive = 1'b0, txStart = 1'b0, swapSel = 1'b0, oscEn = 1'b0;
  logic [7:0] statusByte;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rssi_peak_status #(.CODE_W(3), .OSC_WAIT(WAIT)) i_rssi_peak_status (
    .clk(clk), .rstN(rstN), .envA(envA), .envB(envB), .rxActive(rxActive),
    .txStart(txStart), .swapSel(swapSel), .oscEn(oscEn), .statusByte(statusByte)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    check("R9 reset state", statusByte, 8'h00);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      {txStart, rxActive, swapSel, envA, envB} = VECS[i][14:3+3];
      @(negedge clk);
      check($sformatf("R1/R2-R6 vec %0d", i), statusByte,
            {2'b00, VECS[i][2:0], VECS[i][5:3]});
    end
    {txStart, rxActive, swapSel, envA, envB} = '0;
    // held state now: main 7, aux 0

    oscEn = 1'b1;
    repeat (WAIT - 1) @(negedge clk);
    check("R7 flag not yet", statusByte, 8'h07);
    @(negedge clk);
    check("R7 flag up R1 layout", statusByte, 8'h47);
    #2 oscEn = 1'b0;
    #1 check("R8 flag drops at once", statusByte, 8'h07);
    @(negedge clk);
    oscEn = 1'b1;
    repeat (WAIT - 1) @(negedge clk);
    check("R8 timer restarted", statusByte, 8'h07);
    @(negedge clk);
    check("R8 flag after full wait", statusByte, 8'h47);

    rxActive = 1'b1; envA = 3'd1; envB = 3'd3; swapSel = 1'b0;
    @(negedge clk);
    check("R2 lower main ignored", statusByte, 8'h5F);
    rxActive = 1'b0;
    #5 rstN = 1'b0;
    #1 check("R9 async reset", statusByte, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 stays clear", statusByte, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule